// File: doc/BRIEF.md
# 8-bit Timer with Compare Channels and PWM Waveforms

This block is an 8-bit timer core with two output-compare channels. It advances on single-cycle tick pulses from an external prescaler, and only while a non-zero clock-source code is selected. Four waveform kinds are available: a free-running up-counter, clear-on-compare against channel A, single-slope (fast) PWM, and dual-slope (phase-correct) PWM. Both PWM kinds can take their TOP from 0xFF or from compare A.

Software-facing writes arrive as plain write strobes for the counter, the two compare values and the force strobes. The mode and output-action fields are static inputs. The block raises an overflow flag and two compare flags. Each flag has its own clear input and its own interrupt-enable bit. In PWM kinds the compare values are double-buffered so that a period never sees a torn duty value. In the other kinds a compare write takes effect at once.

Top module: `tmr8_pwm`

## Requirements
- R1: The counter changes only on a cycle with `tick_i` high and `clk_sel_i` non-zero, or on a counter write.
- R2: `mode_i[1:0]` selects the kind: 0 free-running, 1 clear-on-compare, 2 fast PWM, 3 phase-correct PWM. In kind 0 the counter counts up and wraps from 0xFF to 0, and that tick sets `flags_o[0]` (overflow).
- R3: A counter write loads `cnt_wdata_i`. On the next counting tick, no compare match is taken: no compare flag sets and no clear-on-compare clear happens.
- R4: A compare flag (`flags_o[1]` for A, `flags_o[2]` for B) sets on the tick taken while the counter equals the active compare value. It is therefore first seen together with the counter's next value.
- R5: In kind 1 the counter returns to 0 on the tick that matches compare A. In kinds 0 and 1 a compare write takes effect immediately.
- R6: In kinds 0 and 1, an output mode of 1 toggles the waveform on a match, 2 clears it and 3 sets it. An output mode of 0 disconnects the output, which then reads 0.
- R7: A force strobe in kinds 0 or 1 applies the channel's match action without setting a flag or touching the counter. In PWM kinds a force strobe is ignored.
- R8: Fast PWM counts 0..TOP and wraps, and overflow sets on the TOP tick. `mode_i[2]`=1 makes TOP equal compare A; otherwise TOP is 0xFF. Output mode 2 sets the waveform at the wrap and clears it on a match. Output mode 3 is the inverse.
- R9: In PWM kinds a compare write goes to a buffer, and the active value loads from it on the TOP tick.
- R10: Phase-correct PWM counts up to TOP and back down to 0, and overflow sets on the tick that turns at 0. Output mode 2 clears on a match while heading up and sets on a match while heading down. Output mode 3 is the inverse.
- R11: In PWM kinds, output mode 1 toggles output A on each A match only when `mode_i[2]`=1. Otherwise, and always for output B, output mode 1 leaves the output disconnected (0).
- R12: `flag_clr_i[n]` clears flag n, and a set in the same cycle wins. `irq_o[n]` is `flags_o[n]` and `irq_en_i[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable pulse from the prescaler |
| clk_sel_i | input | 3 | Clock-source code; 0 stops the counter |
| mode_i | input | 3 | [1:0] waveform kind, [2] TOP taken from compare A |
| com_a_i | input | 2 | Output action code for channel A |
| com_b_i | input | 2 | Output action code for channel B |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write data |
| ocr_a_we_i | input | 1 | Compare A write strobe |
| ocr_b_we_i | input | 1 | Compare B write strobe |
| ocr_wdata_i | input | 8 | Compare write data |
| force_a_i | input | 1 | Force-compare strobe, channel A |
| force_b_i | input | 1 | Force-compare strobe, channel B |
| flag_clr_i | input | 3 | Flag clears: [0] overflow, [1] A, [2] B |
| irq_en_i | input | 3 | Interrupt enables, same bit order |
| cnt_o | output | 8 | Counter value |
| wave_a_o | output | 1 | Waveform output A |
| wave_b_o | output | 1 | Waveform output B |
| flags_o | output | 3 | Overflow, compare A, compare B flags |
| irq_o | output | 3 | Interrupt requests |

## Verification
A stale active compare value shows at the waveform pins within one PWM period: buffered and direct loading disagree as soon as the counter passes the newly written value. The bench rewrites the compare value mid-period to expose this. A wrong direction bit in phase-correct mode inverts the set/clear choice at the next match and moves the overflow away from the bottom turn. Both errors are visible within one up/down sweep. A stuck write-block flag shows one tick after a counter write, as a compare flag or a clear-on-compare reset that should not have happened.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    K_NORMAL = 2'd0,
    K_CTC    = 2'd1,
    K_FAST   = 2'd2,
    K_PHASE  = 2'd3
  } kind_e;

  localparam int NUM_FLAGS = 3;
  localparam int F_TOV  = 0;
  localparam int F_CMPA = 1;
  localparam int F_CMPB = 2;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  kind_e        kind_i,
  input  logic [W-1:0] top_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         blk_o,
  output logic         top_hit_o,
  output logic         tov_evt_o,
  output logic         going_down_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, cnt_nx;
  logic         dir_up_q, dir_nx;
  logic         blk_q;
  logic         top_hit, tov;

  always_comb begin
    cnt_nx  = cnt_q + ONE;
    dir_nx  = 1'b1;
    top_hit = 1'b0;
    tov     = 1'b0;
    unique case (kind_i)
      K_NORMAL: tov = (cnt_q == MAX);
      K_CTC: begin
        tov = (cnt_q == MAX);
        if (clr_i) cnt_nx = '0;
      end
      K_FAST: begin
        if (cnt_q == top_i) begin
          cnt_nx  = '0;
          top_hit = 1'b1;
          tov     = 1'b1;
        end
      end
      K_PHASE: begin
        if (dir_up_q) begin
          if (cnt_q >= top_i) begin
            dir_nx  = 1'b0;
            top_hit = 1'b1;
            cnt_nx  = (cnt_q == '0) ? '0 : cnt_q - ONE;
          end
        end else if (cnt_q == '0) begin
          dir_nx = 1'b1;
          tov    = 1'b1;
          cnt_nx = (top_i == '0) ? '0 : ONE;
        end else begin
          dir_nx = 1'b0;
          cnt_nx = cnt_q - ONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
      blk_q    <= 1'b0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
      blk_q <= 1'b1;
    end else if (run_i) begin
      cnt_q    <= cnt_nx;
      dir_up_q <= dir_nx;
      blk_q    <= 1'b0;
    end
  end

  assign cnt_o        = cnt_q;
  assign blk_o        = blk_q;
  assign top_hit_o    = run_i && !ld_i && top_hit;
  assign tov_evt_o    = run_i && !ld_i && tov;
  assign going_down_o = (kind_i == K_PHASE) && !dir_nx;

  assert_hold_stopped_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_i) |=> $stable(cnt_q));

  assert_phase_turn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_PHASE && run_i && !ld_i && !dir_up_q && cnt_q == '0) |=> dir_up_q);
endmodule

// File: rtl/tmr8_cmp_chan.sv
module tmr8_cmp_chan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pwm_i,
  input  logic         load_i,
  input  logic [W-1:0] cnt_i,
  input  logic         run_i,
  input  logic         blk_i,
  output logic [W-1:0] ocr_o,
  output logic         match_o
);
  logic [W-1:0] buf_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i) buf_q <= wdata_i;
      if (!pwm_i && we_i) act_q <= wdata_i;
      else if (pwm_i && load_i) act_q <= buf_q;
    end
  end

  assign ocr_o   = act_q;
  assign match_o = run_i && !blk_i && (cnt_i == act_q);

  assert_pwm_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !load_i) |=> $stable(act_q));
endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
  import tmr8_pkg::*;
#(
  parameter bit IS_A = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  kind_e      kind_i,
  input  logic       top_sel_i,
  input  logic [1:0] com_i,
  input  logic       match_i,
  input  logic       force_i,
  input  logic       wrap_i,
  input  logic       going_down_i,
  output logic       wave_o
);
  logic wave_q, wave_nx, pwm, inv, tgl_ok, out_en;

  assign pwm    = (kind_i == K_FAST) || (kind_i == K_PHASE);
  assign inv    = (com_i == 2'd3);
  assign tgl_ok = IS_A && top_sel_i;

  always_comb begin
    wave_nx = wave_q;
    if (!pwm) begin
      if (match_i || force_i) begin
        unique case (com_i)
          2'd1:    wave_nx = !wave_q;
          2'd2:    wave_nx = 1'b0;
          2'd3:    wave_nx = 1'b1;
          default: ;
        endcase
      end
    end else if (com_i == 2'd1) begin
      if (tgl_ok && match_i) wave_nx = !wave_q;
    end else if (com_i[1]) begin
      if (kind_i == K_FAST) begin
        if (wrap_i)       wave_nx = !inv;
        else if (match_i) wave_nx = inv;
      end else if (match_i) begin
        wave_nx = going_down_i ? !inv : inv;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_nx;
  end

  assign out_en = pwm ? (com_i[1] || (com_i == 2'd1 && tgl_ok)) : (com_i != 2'd0);
  assign wave_o = out_en && wave_q;

  assert_pwm_force_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm && force_i && !match_i && !wrap_i) |=> $stable(wave_q));
endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = flag_q & en_i;
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [2:0]   clk_sel_i,
  input  logic [2:0]   mode_i,
  input  logic [1:0]   com_a_i,
  input  logic [1:0]   com_b_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         ocr_a_we_i,
  input  logic         ocr_b_we_i,
  input  logic [W-1:0] ocr_wdata_i,
  input  logic         force_a_i,
  input  logic         force_b_i,
  input  logic [2:0]   flag_clr_i,
  input  logic [2:0]   irq_en_i,
  output logic [W-1:0] cnt_o,
  output logic         wave_a_o,
  output logic         wave_b_o,
  output logic [2:0]   flags_o,
  output logic [2:0]   irq_o
);
  localparam int NCH = 2;

  kind_e          kind;
  logic           top_sel, pwm, run, run_eff;
  logic [W-1:0]   cnt, top;
  logic           blk, top_hit, tov_evt, going_down;
  logic [NCH-1:0] ch_we, ch_match, ch_force, ch_wave;
  logic [W-1:0]   ch_ocr [NCH];
  logic [1:0]     ch_com [NCH];

  assign kind    = kind_e'(mode_i[1:0]);
  assign top_sel = mode_i[2];
  assign pwm     = (kind == K_FAST) || (kind == K_PHASE);
  assign run     = tick_i && (clk_sel_i != 3'd0);
  assign run_eff = run && !cnt_we_i;
  assign top     = (pwm && top_sel) ? ch_ocr[0] : '1;

  assign ch_we    = {ocr_b_we_i, ocr_a_we_i};
  assign ch_force = {force_b_i, force_a_i};
  assign ch_com[0] = com_a_i;
  assign ch_com[1] = com_b_i;

  tmr8_counter #(.W(W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_eff),
    .kind_i      (kind),
    .top_i       (top),
    .ld_i        (cnt_we_i),
    .ld_val_i    (cnt_wdata_i),
    .clr_i       (ch_match[0]),
    .cnt_o       (cnt),
    .blk_o       (blk),
    .top_hit_o   (top_hit),
    .tov_evt_o   (tov_evt),
    .going_down_o(going_down)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr8_cmp_chan #(.W(W)) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (ch_we[c]),
      .wdata_i(ocr_wdata_i),
      .pwm_i  (pwm),
      .load_i (top_hit),
      .cnt_i  (cnt),
      .run_i  (run_eff),
      .blk_i  (blk),
      .ocr_o  (ch_ocr[c]),
      .match_o(ch_match[c])
    );

    tmr8_wavegen #(.IS_A(c == 0)) u_wave (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .kind_i      (kind),
      .top_sel_i   (top_sel),
      .com_i       (ch_com[c]),
      .match_i     (ch_match[c]),
      .force_i     (ch_force[c]),
      .wrap_i      (top_hit),
      .going_down_i(going_down),
      .wave_o      (ch_wave[c])
    );
  end

  tmr8_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({ch_match[1], ch_match[0], tov_evt}),
    .clr_i  (flag_clr_i),
    .en_i   (irq_en_i),
    .flags_o(flags_o),
    .irq_o  (irq_o)
  );

  assign cnt_o    = cnt;
  assign wave_a_o = ch_wave[0];
  assign wave_b_o = ch_wave[1];

  assert_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk && run_eff && flags_o[F_CMPA] == 1'b0 && flags_o[F_CMPB] == 1'b0)
      |=> (flags_o[F_CMPA] == 1'b0 && flags_o[F_CMPB] == 1'b0));

  assert_ctc_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == K_CTC && run_eff && ch_match[0]) |=> (cnt_o == '0));

  assert_tov_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tov_evt |=> flags_o[F_TOV]);

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i[F_TOV] && !tov_evt) |=> !flags_o[F_TOV]);

  assert_force_no_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((force_a_i || force_b_i) && !run && !cnt_we_i) |=> $stable(cnt_o));

  assert_b_toggle_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm && com_b_i == 2'd1) |-> !wave_b_o);
endmodule

// File: tb/tmr8_pwm_tb.sv
module tmr8_pwm_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] clk_sel = '0, mode = '0;
  logic [1:0] com_a = '0, com_b = '0;
  logic       cnt_we = 1'b0, ocr_a_we = 1'b0, ocr_b_we = 1'b0;
  logic [7:0] cnt_wdata = '0, ocr_wdata = '0;
  logic       force_a = 1'b0, force_b = 1'b0;
  logic [2:0] flag_clr = '0, irq_en = '0;
  logic [7:0] cnt;
  logic       wave_a, wave_b;
  logic [2:0] flags, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tmr8_pwm u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .clk_sel_i(clk_sel), .mode_i(mode),
    .com_a_i(com_a), .com_b_i(com_b), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .ocr_a_we_i(ocr_a_we), .ocr_b_we_i(ocr_b_we), .ocr_wdata_i(ocr_wdata),
    .force_a_i(force_a), .force_b_i(force_b), .flag_clr_i(flag_clr), .irq_en_i(irq_en),
    .cnt_o(cnt), .wave_a_o(wave_a), .wave_b_o(wave_b), .flags_o(flags), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 0; clk_sel = 3'd1; mode = 0; com_a = 0; com_b = 0;
    cnt_we = 0; ocr_a_we = 0; ocr_b_we = 0; force_a = 0; force_b = 0;
    flag_clr = 0; irq_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    @(negedge clk) tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk) begin cnt_we = 1'b1; cnt_wdata = v; end
    @(negedge clk) cnt_we = 1'b0;
  endtask

  task automatic wr_ocr(input bit ch_b, input logic [7:0] v);
    @(negedge clk) begin ocr_wdata = v; ocr_a_we = !ch_b; ocr_b_we = ch_b; end
    @(negedge clk) begin ocr_a_we = 1'b0; ocr_b_we = 1'b0; end
  endtask

  task automatic clr_flags();
    @(negedge clk) flag_clr = 3'b111;
    @(negedge clk) flag_clr = 3'b000;
  endtask

  task automatic pulse_force(input bit ch_b);
    @(negedge clk) begin force_a = !ch_b; force_b = ch_b; end
    @(negedge clk) begin force_a = 1'b0; force_b = 1'b0; end
  endtask

  task automatic t_reset_stop();
    do_reset();
    chk("reset cnt", cnt, 0);
    chk("reset flags", flags, 0);
    chk("reset waves", {wave_a, wave_b}, 0);
    chk("reset irq", irq, 0);
    clk_sel = 3'd0;
    ticks(3);
    chk("R1 stopped counter", cnt, 0);
    clk_sel = 3'd1;
    ticks(2);
    chk("R1 running counter", cnt, 2);
  endtask

  task automatic t_overflow();
    do_reset();
    irq_en = 3'b001;
    wr_cnt(8'hFE);
    ticks(1);
    chk("R2 count to FF", cnt, 8'hFF);
    chk("R2 no overflow yet", flags[0], 0);
    ticks(1);
    chk("R2 wrap", cnt, 0);
    chk("R2 overflow flag", flags[0], 1);
    chk("R12 irq enabled", irq[0], 1);
    @(negedge clk) irq_en = 3'b000;
    #1 chk("R12 irq masked", irq[0], 0);
    clr_flags();
    chk("R12 flag cleared", flags[0], 0);
  endtask

  task automatic t_match_timing();
    do_reset();
    wr_ocr(0, 8'd10);
    com_a = 2'd3;
    wr_cnt(8'd8);
    ticks(2);
    chk("R4 cnt at compare", cnt, 10);
    chk("R4 flag not yet", flags[1], 0);
    ticks(1);
    chk("R4 cnt after match", cnt, 11);
    chk("R4 flag set", flags[1], 1);
    chk("R6 set action", wave_a, 1);
    com_a = 2'd2;
    wr_cnt(8'd9);
    ticks(2);
    chk("R6 clear action", wave_a, 0);
    com_a = 2'd3;
    wr_cnt(8'd9);
    ticks(2);
    chk("R6 set again", wave_a, 1);
    @(negedge clk) com_a = 2'd0;
    #1 chk("R6 disconnected", wave_a, 0);
  endtask

  task automatic t_block();
    do_reset();
    mode = 3'd1;
    wr_ocr(0, 8'd20);
    wr_cnt(8'd20);
    ticks(1);
    chk("R3 no ctc clear after write", cnt, 21);
    chk("R3 no flag after write", flags[1], 0);
  endtask

  task automatic t_ctc_force();
    do_reset();
    mode = 3'd1; com_a = 2'd1;
    wr_ocr(0, 8'd5);
    ticks(6);
    chk("R5 ctc cleared", cnt, 0);
    chk("R5 flag on match", flags[1], 1);
    chk("R6 toggle on", wave_a, 1);
    ticks(6);
    chk("R6 toggle off", wave_a, 0);
    clr_flags();
    com_b = 2'd3;
    pulse_force(1);
    chk("R7 force set", wave_b, 1);
    chk("R7 force no flag", flags[2], 0);
    chk("R7 force no count", cnt, 0);
    com_b = 2'd2;
    pulse_force(1);
    chk("R7 force clear", wave_b, 0);
    com_b = 2'd1;
    pulse_force(1);
    chk("R7 force toggle", wave_b, 1);
    mode = 3'd2; com_b = 2'd2;
    pulse_force(1);
    chk("R7 force ignored in pwm", wave_b, 1);
  endtask

  task automatic t_fast();
    do_reset();
    mode = 3'd2; com_a = 2'd2; com_b = 2'd3;
    wr_ocr(0, 8'h40);
    wr_ocr(1, 8'h80);
    ticks(1);
    chk("R8 inverted set on match", wave_b, 1);
    ticks(255);
    chk("R8 wrap at top", cnt, 0);
    chk("R8 overflow at top", flags[0], 1);
    chk("R8 non-inverted set at wrap", wave_a, 1);
    chk("R8 inverted clear at wrap", wave_b, 0);
    ticks(16);
    wr_ocr(0, 8'h20);
    ticks(32);
    chk("R9 cnt", cnt, 8'h30);
    chk("R9 buffered value not yet active", wave_a, 1);
    ticks(17);
    chk("R8 clear at loaded compare", wave_a, 0);
    chk("R8 inverted still low", wave_b, 0);
    ticks(64);
    chk("R8 cnt", cnt, 8'h81);
    chk("R8 inverted set at compare", wave_b, 1);
  endtask

  task automatic t_phase();
    do_reset();
    wr_ocr(0, 8'h10);
    wr_ocr(1, 8'h10);
    mode = 3'd3; com_a = 2'd1; com_b = 2'd2;
    ticks(17);
    chk("R10 up count", cnt, 8'h11);
    chk("R11 A toggle off without top select", wave_a, 0);
    chk("R10 up match clears", wave_b, 0);
    ticks(239);
    chk("R10 turned at top", cnt, 8'hFE);
    chk("R10 no overflow at top", flags[0], 0);
    ticks(238);
    chk("R10 down to compare", cnt, 8'h10);
    chk("R10 low before down match", wave_b, 0);
    ticks(1);
    chk("R10 down match sets", wave_b, 1);
    ticks(15);
    chk("R10 at bottom", cnt, 0);
    chk("R10 overflow not before bottom turn", flags[0], 0);
    ticks(1);
    chk("R10 turned at bottom", cnt, 1);
    chk("R10 overflow at bottom", flags[0], 1);
    ticks(16);
    chk("R10 up match clears again", wave_b, 0);
  endtask

  task automatic t_phase_top_a();
    do_reset();
    wr_ocr(0, 8'd8);
    wr_ocr(1, 8'd4);
    mode = 3'd7; com_a = 2'd1; com_b = 2'd1;
    ticks(8);
    chk("R10 top from A", cnt, 8);
    chk("R11 A before match", wave_a, 0);
    ticks(1);
    chk("R10 turn at A", cnt, 7);
    chk("R11 A toggled", wave_a, 1);
    chk("R11 B toggle disconnected", wave_b, 0);
    ticks(8);
    chk("R10 bottom turn", cnt, 1);
    chk("R10 overflow", flags[0], 1);
    pulse_force(0);
    chk("R7 force ignored", wave_a, 1);
    ticks(8);
    chk("R11 A toggled back", wave_a, 0);
  endtask

  initial begin
    t_reset_stop();
    t_overflow();
    t_match_timing();
    t_block();
    t_ctc_force();
    t_fast();
    t_phase();
    t_phase_top_a();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule